// File: doc/BRIEF.md
# Two-byte-addressed serial memory slave

This block is the slave side of a two-wire serial memory. It watches a clock line and a data line, finds start and stop conditions, and receives a device-address byte. When the byte's type prefix and 3-bit select field match this device, it acknowledges. A write then takes two word-address bytes, which set a 13-bit location pointer, followed by data bytes that are stored at that pointer. A read returns bytes from the pointer and advances it after each byte. A read can be entered directly, from the current pointer, or through a repeated start after the word address.

The data line is open-drain. The block never drives it high. Its only output is a pull-low enable, used for acknowledge bits and for the zeros of read data. A write-protect input blocks every store, while the address phase still works as usual. Both bus lines are resynchronised into the system clock before the protocol logic uses them. The byte storage is a synchronous array that can map onto block RAM. Its depth is a parameter, and locations above that depth alias onto the stored range.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the pull-low enable `sda_oe_o` is 0 and the slave is idle.
- R2: A start condition is the data line falling while the clock is high. Before the first start, clocked bytes are ignored and not acknowledged.
- R3: The device byte is sent MSB first as type prefix 1010, then the select bits, then R/W (1 = read). The select bits are compared with `strap_i[2]`, `strap_i[1]`, `strap_i[0]` in that order. On a match the slave acknowledges by pulling the data line low in the ninth clock. On a mismatch of the prefix or of the select bits it does not acknowledge, and it ignores all following bytes until the next start.
- R4: After a write device byte, the next two bytes form the pointer. The first byte supplies bits 12..8 from its low 5 bits, and its upper 3 bits are ignored. The second byte supplies bits 7..0. Both bytes are acknowledged.
- R5: With `wp_i` low, each following data byte is acknowledged and stored at the pointer. The pointer then advances by one, and it wraps from 0x1FFF to 0x0000.
- R6: With `wp_i` high, the device and pointer bytes are still acknowledged. Every data byte is not acknowledged, nothing is stored and the pointer does not advance. Reads are unaffected.
- R7: A read device byte, whether sent after a repeated start or on its own, returns the byte at the pointer, MSB first. The pointer advances after each read byte and wraps at 13 bits, so a read started at 0x1FFF continues at 0x0000.
- R8: During the master's acknowledge slot of a read byte the slave releases the line. If the master does not acknowledge, the slave stays released until the next start.
- R9: The slave changes its pull-low enable only while the clock line is low. It starts driving a bit only after a clock falling edge, so the line is stable while the clock is high.
- R10: A stop condition, the data line rising while the clock is high, ends any transaction. Bytes clocked after it without a new start are not acknowledged.
- R11: Storage holds 2^MEM_AW bytes (2048 by default). A pointer value selects the byte at its low MEM_AW bits, so 0x0923 and 0x0123 are the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus) |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Write protect, high blocks stores |
| sda_oe_o | output | 1 | Pull-low enable for the data line |

## Verification
The hardest condition to reach from the ports is the pointer wrap, and the aliasing of wide pointer values onto the smaller array. Both can only be reached through complete header sequences on the serial bus. The stimulus writes a header for 0x1FFF and streams two data bytes across the wrap. It then re-addresses 0x1FFF and reads across the same boundary through a repeated start. A header for 0x0923 followed by a current-location read shows that the alias returns the byte stored at 0x0123. Write protect is toggled only between transactions. Its effect is seen as a missing data acknowledge and as unchanged data on a later read.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int TYPE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WHI,
    ST_WLO,
    ST_WDAT,
    ST_RDAT
  } ctl_st_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  // index 1 = clock line, index 0 = data line
  logic [1:0] chain [STAGES];
  logic [1:0] prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 2'b11;
        else     chain[g] <= {scl_i, sda_i};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= 2'b11;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 2'b11;
    else     prev_q <= chain[STAGES-1];
  end

  assign scl_lvl  = chain[STAGES-1][1];
  assign sda_lvl  = chain[STAGES-1][0];
  assign scl_rise = scl_lvl & ~prev_q[1];
  assign scl_fall = ~scl_lvl & prev_q[1];
  assign start_ev = scl_lvl & prev_q[1] & prev_q[0] & ~sda_lvl;
  assign stop_ev  = scl_lvl & prev_q[1] & ~prev_q[0] & sda_lvl;
endmodule

// File: rtl/byte_ram.sv
module byte_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/proto_fsm.sv
module proto_fsm
  import smem_pkg::*;
#(
  parameter int                PTR_W     = 13,
  parameter int                MEM_AW    = 11,
  parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [SEL_W-1:0]  strap,
  input  logic              wp,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              we,
  output logic [MEM_AW-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic [MEM_AW-1:0] raddr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam int HI_W  = PTR_W - BYTE_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  ctl_st_t           st, nxt;
  logic [CNT_W-1:0]  bitcnt;
  logic              in_ack;
  logic              mack;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] txreg;
  logic [PTR_W-1:0]  ptr;
  logic [IDX_W-1:0]  tx_idx;
  logic              dev_hit;

  assign tx_idx  = IDX_W'(BYTE_W - 1) - bitcnt[IDX_W-1:0];
  assign dev_hit = (shreg[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                   (shreg[SEL_W:1] == strap);
  assign raddr   = ptr[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    we <= 1'b0;
    if (rst) begin
      st     <= ST_IDLE;
      nxt    <= ST_IDLE;
      bitcnt <= '0;
      in_ack <= 1'b0;
      mack   <= 1'b0;
      shreg  <= '0;
      txreg  <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      waddr  <= '0;
      wdata  <= '0;
    end else if (start_ev) begin
      st     <= ST_DEV;
      bitcnt <= '0;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (st == ST_RDAT) begin
      if (scl_rise) begin
        if (in_ack) mack   <= sda_lvl;
        else        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          if (mack) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
          end else begin
            txreg  <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
          end
        end else if (bitcnt == FULL) begin
          in_ack <= 1'b1;
          sda_oe <= 1'b0;
          ptr    <= ptr + 1'b1;
        end else begin
          sda_oe <= ~txreg[tx_idx];
        end
      end
    end else if (st != ST_IDLE) begin
      if (scl_rise && !in_ack) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
        bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          st     <= nxt;
          if (nxt == ST_RDAT) begin
            txreg  <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
          end else begin
            sda_oe <= 1'b0;
          end
        end else if (bitcnt == FULL) begin
          in_ack <= 1'b1;
          case (st)
            ST_DEV: begin
              if (dev_hit) begin
                sda_oe <= 1'b1;
                nxt    <= shreg[0] ? ST_RDAT : ST_WHI;
              end else begin
                st     <= ST_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
              end
            end
            ST_WHI: begin
              ptr[PTR_W-1:BYTE_W] <= shreg[HI_W-1:0];
              sda_oe <= 1'b1;
              nxt    <= ST_WLO;
            end
            ST_WLO: begin
              ptr[BYTE_W-1:0] <= shreg;
              sda_oe <= 1'b1;
              nxt    <= ST_WDAT;
            end
            ST_WDAT: begin
              nxt <= ST_WDAT;
              if (!wp) begin
                we     <= 1'b1;
                waddr  <= ptr[MEM_AW-1:0];
                wdata  <= shreg;
                ptr    <= ptr + 1'b1;
                sda_oe <= 1'b1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
            default: begin
              st     <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          endcase
        end
      end
    end
  end

  // R9
  oe_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);

  // R2
  start_reset_chk: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (st == ST_DEV && !sda_oe && bitcnt == '0));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (st == ST_IDLE));

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> !$past(wp));

  // R5
  write_ack_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> sda_oe);

  // R8
  master_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RDAT && in_ack) |-> !sda_oe);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import smem_pkg::*;
#(
  parameter int                PTR_W       = 13,
  parameter int                MEM_AW      = 11,
  parameter int                SYNC_STAGES = 2,
  parameter logic [TYPE_W-1:0] TYPE_CODE   = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] strap_i,
  input  logic             wp_i,
  output logic             sda_oe_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic              we;
  logic [MEM_AW-1:0] waddr, raddr;
  logic [BYTE_W-1:0] wdata, rdata;

  bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  proto_fsm #(.PTR_W(PTR_W), .MEM_AW(MEM_AW), .TYPE_CODE(TYPE_CODE)) ctl_i (
    .clk(clk), .rst(rst),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .strap(strap_i), .wp(wp_i), .rd_data(rdata),
    .sda_oe(sda_oe_o), .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr)
  );

  byte_ram #(.AW(MEM_AW), .DW(BYTE_W)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );
endmodule

// File: tb/serial_mem_slave_tb_top.sv
`timescale 1ns/1ps
module serial_mem_slave_tb_top;
  localparam int H     = 20;
  localparam int DEPTH = 2048;
  localparam int PMOD  = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic [2:0] strap = 3'b101;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_chg = 0;
  bit run = 1'b0;
  bit done = 1'b0;
  logic exp_oe = 1'b0;

  logic [7:0] mdl [DEPTH];
  int mptr = 0;

  assign sda_line = sda_drv & ~sda_oe;

  always #10 clk = ~clk;

  serial_mem_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line),
    .strap_i(strap), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  // per-clock comparison of the pull-low enable against the model (R9)
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (run && (cyc - last_chg) > 8) begin
      checks = checks + 1;
      if (sda_oe !== exp_oe) begin
        errors = errors + 1;
        $display("FAIL R9 cycle %0d pull-low act=%0b exp=%0b", cyc, sda_oe, exp_oe);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_scl(input logic v);
    scl_drv = v;
    last_chg = cyc;
  endtask

  task automatic set_sda(input logic v);
    sda_drv = v;
    last_chg = cyc;
  endtask

  task automatic sbit(input logic b);
    tick(4); set_sda(b); tick(H - 4);
    set_scl(1'b1); tick(H);
    set_scl(1'b0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    exp_oe = exp_ack;
    tick(4); set_sda(1'b1); tick(H - 4);
    set_scl(1'b1); tick(H / 2);
    chk(sda_line == !exp_ack, tag, sda_line, !exp_ack);
    tick(H / 2);
    set_scl(1'b0);
    exp_oe = 1'b0;
  endtask

  task automatic recv_byte(input bit master_ack, input string tag);
    logic [7:0] want;
    logic [7:0] got;
    want = mdl[mptr % DEPTH];
    got = '0;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = !want[i];
      tick(4); set_sda(1'b1); tick(H - 4);
      set_scl(1'b1); tick(H / 2);
      got[i] = sda_line;
      tick(H / 2);
      set_scl(1'b0);
    end
    exp_oe = 1'b0;
    chk(got == want, tag, got, want);
    mptr = (mptr + 1) % PMOD;
    tick(4); set_sda(master_ack ? 1'b0 : 1'b1); tick(H - 4);
    set_scl(1'b1); tick(H);
    set_scl(1'b0);
  endtask

  task automatic bus_start();
    set_sda(1'b1); tick(H);
    set_scl(1'b1); tick(H);
    set_sda(1'b0); exp_oe = 1'b0; tick(H);
    set_scl(1'b0);
  endtask

  task automatic bus_stop();
    tick(4); set_sda(1'b0); tick(H - 4);
    set_scl(1'b1); tick(H);
    set_sda(1'b1); exp_oe = 1'b0; tick(H);
  endtask

  task automatic wr_hdr(input logic [7:0] hi, input logic [7:0] lo);
    bus_start();
    send_byte(8'hAA, 1'b1, "R3");
    send_byte(hi, 1'b1, "R4");
    send_byte(lo, 1'b1, "R4");
    mptr = {hi[4:0], lo};
  endtask

  task automatic wr_data(input logic [7:0] b, input string tag);
    send_byte(b, !wp, tag);
    if (!wp) begin
      mdl[mptr % DEPTH] = b;
      mptr = (mptr + 1) % PMOD;
    end
  endtask

  initial begin
    tick(5);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    rst = 1'b0;
    tick(5);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    chk(sda_line == 1'b1, "R1", sda_line, 1);
    run = 1'b1;

    // R2: bytes before any start are ignored
    set_scl(1'b0);
    send_byte(8'hAA, 1'b0, "R2");
    bus_stop();

    // R4 R5: write with ignored upper pointer bits, sequential store
    wr_hdr(8'hE1, 8'h23);
    wr_data(8'h5C, "R5");
    wr_data(8'h7E, "R5");
    bus_stop();
    chk(mptr == 32'h125, "R4", mptr, 32'h125);

    // R3: select mismatch, then type mismatch
    bus_start();
    send_byte(8'hA2, 1'b0, "R3");
    send_byte(8'h55, 1'b0, "R3");
    bus_stop();
    bus_start();
    send_byte(8'hBA, 1'b0, "R3");
    bus_stop();

    // R7 R8: random read via repeated start
    wr_hdr(8'h01, 8'h23);
    bus_start();
    send_byte(8'hAB, 1'b1, "R7");
    recv_byte(1'b1, "R7");
    recv_byte(1'b0, "R8");
    send_byte(8'hFF, 1'b0, "R8");
    bus_stop();

    // R6: write protect
    wp = 1'b1;
    wr_hdr(8'h01, 8'h23);
    wr_data(8'h99, "R6");
    bus_stop();
    wp = 1'b0;
    wr_hdr(8'h01, 8'h23);
    bus_start();
    send_byte(8'hAB, 1'b1, "R6");
    recv_byte(1'b0, "R6");
    bus_stop();

    // R5 R7: pointer wrap at 13 bits
    wr_hdr(8'h1F, 8'hFF);
    wr_data(8'h11, "R5");
    wr_data(8'h22, "R5");
    bus_stop();
    wr_hdr(8'h1F, 8'hFF);
    bus_start();
    send_byte(8'hAB, 1'b1, "R7");
    recv_byte(1'b1, "R7");
    recv_byte(1'b0, "R7");
    bus_stop();

    // R11: alias 0x0923 onto 0x0123 with a current-location read
    wr_hdr(8'h09, 8'h23);
    bus_stop();
    chk(mdl[mptr % DEPTH] == 8'h5C, "R11", mdl[mptr % DEPTH], 8'h5C);
    bus_start();
    send_byte(8'hAB, 1'b1, "R11");
    recv_byte(1'b0, "R11");
    bus_stop();

    // R10: stop ends transaction; later bytes without start ignored
    bus_start();
    send_byte(8'hAA, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    bus_stop();
    set_scl(1'b0);
    send_byte(8'h03, 1'b0, "R10");
    bus_stop();

    tick(20);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors = errors + 1;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule